// File: doc/BRIEF.md
# Register Rename Map Table

This block keeps the speculative mapping from architectural register numbers to physical register numbers in an out-of-order core. One flat architectural index space is split, in ascending order, into an integer range, a floating-point range and a range of miscellaneous registers. Integer and floating-point registers each have their own map bank. Miscellaneous registers are never renamed. They are translated at a fixed offset that places them above the whole physical register file.

A rename request reads the current mapping of its target and returns it as the previous register. In the same cycle it takes a fresh register from the matching external free list and returns that as the new register. The map entry is overwritten on the next clock edge. A read-only lookup port and a direct set-entry port serve operand reads and recovery. The block also reports how many rename slots are free, which is the smaller of the two free-list counts.

Top module: `rmt_map_table`

## Requirements
- R1: After reset, integer architectural register i maps to physical register INT_BASE+i, and floating-point architectural register NLI+j maps to physical register FP_BASE+j. With the default parameters INT_BASE is 0 and FP_BASE is 64.
- R2: A rename of a non-zero integer register with fl_int_count nonzero sets ren_ready. It returns the current mapping on ren_prev and fl_int_reg on ren_new, and pulses fl_int_take for that cycle. From the next cycle, lookup of that register returns the new register.
- R3: A rename of the integer zero register (index INT_ZERO, default 0) is always ready. It takes from neither free list and returns INT_ZERO on ren_new. Its map entry does not change.
- R4: A rename of a floating-point register (indices NLI to NLI+NLF-1) allocates from the floating-point list: ren_new is fl_fp_reg and fl_fp_take pulses. When FP_ZERO_EN is 1, index FP_ZERO (default 63) is exempt in the same way as R3 and returns FP_ZERO on ren_new.
- R5: A rename of a miscellaneous register a (index at least NLI+NLF) returns (a-NLI-NLF)+NPI+NPF on both ren_new and ren_prev. It takes no free register and is always ready.
- R6: Lookup returns the current mapping for integer and floating-point registers and the translation of R5 for miscellaneous registers. It never changes the map.
- R7: A set-entry write with set_valid high overwrites the integer or floating-point entry of set_arch from the next cycle. A set-entry write to a miscellaneous index has no effect.
- R8: free_slots equals the smaller of fl_int_count and fl_fp_count.
- R9: A rename that needs a register from a list whose count is zero drives ren_ready low. It pulses no take and leaves the map unchanged.
- R10: A lookup in the same cycle as a rename of the same register returns the mapping from before the rename.
- R11: When a set-entry write and an allocating rename target the same entry in one cycle, the set-entry value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, rebinds the maps |
| ren_valid | input | 1 | Rename request present |
| ren_arch | input | AW | Architectural index to rename |
| ren_ready | output | 1 | Rename can complete this cycle |
| ren_new | output | PW | Newly assigned physical register |
| ren_prev | output | PW | Physical register mapped before the rename |
| lk_arch | input | AW | Architectural index to look up |
| lk_phys | output | PW | Current physical register for lk_arch |
| set_valid | input | 1 | Direct map write request |
| set_arch | input | AW | Architectural index to overwrite |
| set_phys | input | PW | Physical register to store |
| fl_int_count | input | CW | Free integer registers available |
| fl_int_reg | input | PW | Integer register offered by the free list |
| fl_int_take | output | 1 | Integer free list pops its offered register |
| fl_fp_count | input | CW | Free floating-point registers available |
| fl_fp_reg | input | PW | Floating-point register offered by the free list |
| fl_fp_take | output | 1 | Floating-point free list pops its offered register |
| free_slots | output | CW | Smaller of the two free counts |

## Verification
The assertions assume that every architectural index on ren_arch, lk_arch and set_arch lies inside the three defined ranges. They also assume each free list offers a register from its own physical range whenever its count is nonzero. Both counts must stay stable within a cycle. The stimulus draws indices only from the valid space and draws offered registers from the matching physical range. It makes counts zero often enough to exercise stalls, and it mixes in set-entry writes to miscellaneous indices and same-cycle collisions.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } rmt_cls_e;

  // fixed translation of a non-renamed register into the space above the file
  function automatic int misc_xlate(input int arch, input int nlog, input int nphys);
    return (arch - nlog) + nphys;
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/rmt_decode.sv
module rmt_decode
  import rmt_pkg::*;
#(
  parameter int AW  = 7,
  parameter int NLI = 32,
  parameter int NLF = 32,
  parameter int IW  = 5,
  parameter int FW  = 5
) (
  input  logic [AW-1:0] arch,
  output rmt_cls_e      cls,
  output logic [IW-1:0] int_idx,
  output logic [FW-1:0] fp_idx
);
  localparam int NLOG = NLI + NLF;

  always_comb begin
    if (arch < AW'(NLI))       cls = CLS_INT;
    else if (arch < AW'(NLOG)) cls = CLS_FP;
    else                       cls = CLS_MISC;
    int_idx = IW'(arch);
    fp_idx  = FW'(arch - AW'(NLI));
  end
endmodule

// File: rtl/rmt_bank.sv
module rmt_bank #(
  parameter int N    = 32,
  parameter int IW   = 5,
  parameter int PW   = 8,
  parameter int BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  output logic [PW-1:0] rd_a_phys,
  input  logic [IW-1:0] rd_b_idx,
  output logic [PW-1:0] rd_b_phys,
  input  logic          ren_we,
  input  logic [IW-1:0] ren_idx,
  input  logic [PW-1:0] ren_phys,
  input  logic          set_we,
  input  logic [IW-1:0] set_idx,
  input  logic [PW-1:0] set_phys
);
  logic [PW-1:0] ent [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= PW'(BASE + i);
      else if (set_we && set_idx == IW'(i))
        ent[i] <= set_phys;             // recovery write wins
      else if (ren_we && ren_idx == IW'(i))
        ent[i] <= ren_phys;
    end
  end

  assign rd_a_phys = ent[rd_a_idx];
  assign rd_b_phys = ent[rd_b_idx];
endmodule

// File: rtl/rmt_alloc.sv
module rmt_alloc
  import rmt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          ren_valid,
  input  rmt_cls_e      ren_cls,
  input  logic          ren_zero,
  input  logic [CW-1:0] int_count,
  input  logic [CW-1:0] fp_count,
  output logic          ren_ready,
  output logic          int_take,
  output logic          fp_take,
  output logic [CW-1:0] free_slots
);
  logic need_int, need_fp;

  always_comb begin
    need_int = (ren_cls == CLS_INT) && !ren_zero;
    need_fp  = (ren_cls == CLS_FP) && !ren_zero;
    if (need_int)     ren_ready = (int_count != '0);
    else if (need_fp) ren_ready = (fp_count != '0);
    else              ren_ready = 1'b1;
    int_take   = ren_valid && need_int && (int_count != '0);
    fp_take    = ren_valid && need_fp && (fp_count != '0);
    free_slots = CW'(min2(int'(int_count), int'(fp_count)));
  end
endmodule

// File: rtl/rmt_map_table.sv
module rmt_map_table
  import rmt_pkg::*;
#(
  parameter int NLI        = 32,
  parameter int NLF        = 32,
  parameter int NMISC      = 8,
  parameter int NPI        = 64,
  parameter int NPF        = 64,
  parameter int INT_BASE   = 0,
  parameter int FP_BASE    = 64,
  parameter int INT_ZERO   = 0,
  parameter int FP_ZERO    = 63,
  parameter bit FP_ZERO_EN = 1'b1,
  parameter int CW         = 8,
  localparam int AW = $clog2(NLI + NLF + NMISC),
  localparam int PW = $clog2(NPI + NPF + NMISC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  output logic          ren_ready,
  output logic [PW-1:0] ren_new,
  output logic [PW-1:0] ren_prev,
  input  logic [AW-1:0] lk_arch,
  output logic [PW-1:0] lk_phys,
  input  logic          set_valid,
  input  logic [AW-1:0] set_arch,
  input  logic [PW-1:0] set_phys,
  input  logic [CW-1:0] fl_int_count,
  input  logic [PW-1:0] fl_int_reg,
  output logic          fl_int_take,
  input  logic [CW-1:0] fl_fp_count,
  input  logic [PW-1:0] fl_fp_reg,
  output logic          fl_fp_take,
  output logic [CW-1:0] free_slots
);
  localparam int NLOG  = NLI + NLF;
  localparam int NPHYS = NPI + NPF;
  localparam int IW    = $clog2(NLI);
  localparam int FW    = $clog2(NLF);

  rmt_cls_e      ren_cls, lk_cls, set_cls;
  logic [IW-1:0] ren_iidx, lk_iidx, set_iidx;
  logic [FW-1:0] ren_fidx, lk_fidx, set_fidx;
  logic          ren_zero;
  logic          map_write;
  logic [PW-1:0] ren_misc, lk_misc;
  logic [PW-1:0] int_prev, int_lk, fp_prev, fp_lk;

  rmt_decode #(.AW(AW), .NLI(NLI), .NLF(NLF), .IW(IW), .FW(FW)) u_dec_ren (
    .arch(ren_arch), .cls(ren_cls), .int_idx(ren_iidx), .fp_idx(ren_fidx));
  rmt_decode #(.AW(AW), .NLI(NLI), .NLF(NLF), .IW(IW), .FW(FW)) u_dec_lk (
    .arch(lk_arch), .cls(lk_cls), .int_idx(lk_iidx), .fp_idx(lk_fidx));
  rmt_decode #(.AW(AW), .NLI(NLI), .NLF(NLF), .IW(IW), .FW(FW)) u_dec_set (
    .arch(set_arch), .cls(set_cls), .int_idx(set_iidx), .fp_idx(set_fidx));

  // hardwired zero registers bypass allocation
  assign ren_zero = ((ren_cls == CLS_INT) && (ren_arch == AW'(INT_ZERO))) ||
                    (FP_ZERO_EN && (ren_cls == CLS_FP) && (ren_arch == AW'(FP_ZERO)));

  assign ren_misc = PW'(misc_xlate(int'(ren_arch), NLOG, NPHYS));
  assign lk_misc  = PW'(misc_xlate(int'(lk_arch), NLOG, NPHYS));

  rmt_alloc #(.CW(CW)) u_alloc (
    .ren_valid(ren_valid), .ren_cls(ren_cls), .ren_zero(ren_zero),
    .int_count(fl_int_count), .fp_count(fl_fp_count),
    .ren_ready(ren_ready), .int_take(fl_int_take), .fp_take(fl_fp_take),
    .free_slots(free_slots));

  rmt_bank #(.N(NLI), .IW(IW), .PW(PW), .BASE(INT_BASE)) u_int_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ren_iidx), .rd_a_phys(int_prev),
    .rd_b_idx(lk_iidx), .rd_b_phys(int_lk),
    .ren_we(fl_int_take), .ren_idx(ren_iidx), .ren_phys(fl_int_reg),
    .set_we(set_valid && set_cls == CLS_INT), .set_idx(set_iidx), .set_phys(set_phys));

  rmt_bank #(.N(NLF), .IW(FW), .PW(PW), .BASE(FP_BASE)) u_fp_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ren_fidx), .rd_a_phys(fp_prev),
    .rd_b_idx(lk_fidx), .rd_b_phys(fp_lk),
    .ren_we(fl_fp_take), .ren_idx(ren_fidx), .ren_phys(fl_fp_reg),
    .set_we(set_valid && set_cls == CLS_FP), .set_idx(set_fidx), .set_phys(set_phys));

  assign map_write = fl_int_take || fl_fp_take || set_valid;

  always_comb begin
    unique case (ren_cls)
      CLS_INT:  ren_prev = int_prev;
      CLS_FP:   ren_prev = fp_prev;
      default:  ren_prev = ren_misc;
    endcase
    if (ren_cls == CLS_MISC)  ren_new = ren_misc;
    else if (ren_zero)        ren_new = PW'(ren_arch);
    else if (ren_cls == CLS_INT) ren_new = fl_int_reg;
    else                      ren_new = fl_fp_reg;
    unique case (lk_cls)
      CLS_INT:  lk_phys = int_lk;
      CLS_FP:   lk_phys = fp_lk;
      default:  lk_phys = lk_misc;
    endcase
  end
endmodule

// File: rtl/rmt_map_table_chk.sv
module rmt_map_table_chk
  import rmt_pkg::*;
#(
  parameter int AW = 7,
  parameter int PW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic          ren_ready,
  input logic [PW-1:0] ren_new,
  input logic [PW-1:0] ren_prev,
  input rmt_cls_e      ren_cls,
  input logic          ren_zero,
  input logic [AW-1:0] lk_arch,
  input logic [PW-1:0] lk_phys,
  input logic          map_write,
  input logic [CW-1:0] fl_int_count,
  input logic          fl_int_take,
  input logic [CW-1:0] fl_fp_count,
  input logic          fl_fp_take,
  input logic [CW-1:0] free_slots
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r9_int_take_stock: assert property (@(posedge clk) disable iff (!rst_n)
    fl_int_take |-> fl_int_count != '0);
  a_r9_fp_take_stock: assert property (@(posedge clk) disable iff (!rst_n)
    fl_fp_take |-> fl_fp_count != '0);
  a_r9_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_cls == CLS_INT && !ren_zero && fl_int_count == '0)
      |-> (!ren_ready && !fl_int_take));
  a_r3_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_zero) |-> (ren_ready && !fl_int_take && !fl_fp_take));
  a_r5_misc_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_cls == CLS_MISC)
      |-> (ren_new == ren_prev && ren_ready && !fl_int_take && !fl_fp_take));
  a_r2_one_list: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_int_take, fl_fp_take}));
  a_r8_free_min: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots <= fl_int_count) && (free_slots <= fl_fp_count) &&
    ((free_slots == fl_int_count) || (free_slots == fl_fp_count)));
  a_r6_lookup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(map_write) && $stable(lk_arch)) |-> $stable(lk_phys));
endmodule

bind rmt_map_table rmt_map_table_chk #(.AW(AW), .PW(PW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_new(ren_new), .ren_prev(ren_prev), .ren_cls(ren_cls), .ren_zero(ren_zero),
  .lk_arch(lk_arch), .lk_phys(lk_phys), .map_write(map_write),
  .fl_int_count(fl_int_count), .fl_int_take(fl_int_take),
  .fl_fp_count(fl_fp_count), .fl_fp_take(fl_fp_take), .free_slots(free_slots));

// File: tb/rmt_map_table_tb_top.sv
module rmt_map_table_tb_top;
  localparam int NLI = 32, NLF = 32, NMISC = 8, NPI = 64, NPF = 64;
  localparam int INT_BASE = 0, FP_BASE = 64, INT_ZERO = 0, FP_ZERO = 63;
  localparam int NLOG = NLI + NLF, NPHYS = NPI + NPF, NARCH = NLOG + NMISC;
  localparam int AW = 7, PW = 8, CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          ren_valid = 1'b0, set_valid = 1'b0;
  logic [AW-1:0] ren_arch = '0, lk_arch = '0, set_arch = '0;
  logic [PW-1:0] set_phys = '0, fl_int_reg = '0, fl_fp_reg = '0;
  logic [CW-1:0] fl_int_count = '0, fl_fp_count = '0;
  logic          ren_ready, fl_int_take, fl_fp_take;
  logic [PW-1:0] ren_new, ren_prev, lk_phys;
  logic [CW-1:0] free_slots;

  rmt_map_table dut_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
    .ren_ready(ren_ready), .ren_new(ren_new), .ren_prev(ren_prev),
    .lk_arch(lk_arch), .lk_phys(lk_phys), .set_valid(set_valid),
    .set_arch(set_arch), .set_phys(set_phys), .fl_int_count(fl_int_count),
    .fl_int_reg(fl_int_reg), .fl_int_take(fl_int_take), .fl_fp_count(fl_fp_count),
    .fl_fp_reg(fl_fp_reg), .fl_fp_take(fl_fp_take), .free_slots(free_slots));

  int checks = 0, failures = 0;
  int imap [NLI];
  int fmap [NLF];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int misc_of(input int a);
    return a - NLOG + NPHYS;
  endfunction

  function automatic int map_of(input int a);
    if (a < NLI) return imap[a];
    if (a < NLOG) return fmap[a - NLI];
    return misc_of(a);
  endfunction

  function automatic int minv(input int a, input int b);
    if (b < a) return b;
    return a;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NLI; i++) imap[i] = INT_BASE + i;
    for (int j = 0; j < NLF; j++) fmap[j] = FP_BASE + j;
  endtask

  // one cycle: drive at falling edge, check, then update the model for the rising edge
  task automatic cyc(input bit rv, input int ra, input int la, input bit sv, input int sa,
                     input int sp, input int ic, input int fc, input int ir, input int fr,
                     input string lk_tag);
    bit is_int, is_fp, is_zero, need_i, need_f, rdy;
    int exp_new, exp_prev;
    string rtag;
    @(negedge clk);
    ren_valid = rv; ren_arch = AW'(ra); lk_arch = AW'(la);
    set_valid = sv; set_arch = AW'(sa); set_phys = PW'(sp);
    fl_int_count = CW'(ic); fl_fp_count = CW'(fc);
    fl_int_reg = PW'(ir); fl_fp_reg = PW'(fr);
    #1;
    is_int  = ra < NLI;
    is_fp   = (ra >= NLI) && (ra < NLOG);
    is_zero = (is_int && ra == INT_ZERO) || (is_fp && ra == FP_ZERO);
    need_i  = is_int && !is_zero;
    need_f  = is_fp && !is_zero;
    rdy     = need_i ? (ic != 0) : need_f ? (fc != 0) : 1'b1;
    exp_prev = map_of(ra);
    if (!is_int && !is_fp) begin exp_new = misc_of(ra); rtag = "R5"; end
    else if (is_zero)      begin exp_new = ra; rtag = is_int ? "R3" : "R4"; end
    else if (is_int)       begin exp_new = ir; rtag = "R2"; end
    else                   begin exp_new = fr; rtag = "R4"; end
    chk("R9", "ren_ready", int'(ren_ready), int'(rdy));
    chk("R8", "free_slots", int'(free_slots), minv(ic, fc));
    chk(lk_tag, "lk_phys", int'(lk_phys), map_of(la));
    if (rv) begin
      chk(rtag, "ren_prev", int'(ren_prev), exp_prev);
      chk(rtag, "ren_new", int'(ren_new), exp_new);
    end
    chk(rdy ? rtag : "R9", "fl_int_take", int'(fl_int_take), int'(rv && need_i && ic != 0));
    chk(rdy ? rtag : "R9", "fl_fp_take", int'(fl_fp_take), int'(rv && need_f && fc != 0));
    if (rv && need_i && ic != 0) imap[ra] = ir;
    if (rv && need_f && fc != 0) fmap[ra - NLI] = fr;
    if (sv && sa < NLI) imap[sa] = sp;                 // R11: set applied last
    else if (sv && sa < NLOG) fmap[sa - NLI] = sp;
    @(posedge clk);
  endtask

  initial begin
    #(8 * 180000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 and R6: reset binding and misc translation through lookup
    for (int a = 0; a < NARCH; a++)
      cyc(0, 0, a, 0, 0, 0, 2, 2, 1, 70, (a < NLOG) ? "R1" : "R6");
    // R2 with R10: same-cycle lookup sees old mapping
    cyc(1, 5, 5, 0, 0, 0, 3, 3, 40, 100, "R10");
    cyc(0, 0, 5, 0, 0, 0, 3, 3, 40, 100, "R2");
    // R3: zero register with empty integer list
    cyc(1, INT_ZERO, 0, 0, 0, 0, 0, 3, 41, 100, "R3");
    cyc(0, 0, INT_ZERO, 0, 0, 0, 0, 3, 41, 100, "R3");
    // R4: float rename and float zero with empty float list
    cyc(1, 40, 40, 0, 0, 0, 3, 3, 41, 101, "R10");
    cyc(1, FP_ZERO, 40, 0, 0, 0, 3, 0, 41, 102, "R4");
    cyc(0, 0, FP_ZERO, 0, 0, 0, 3, 0, 41, 102, "R4");
    // R5: misc rename
    cyc(1, 66, 66, 0, 0, 0, 0, 0, 42, 103, "R6");
    // R9: stall on empty list leaves map unchanged
    cyc(1, 7, 7, 0, 0, 0, 0, 4, 43, 104, "R9");
    cyc(0, 0, 7, 0, 0, 0, 0, 4, 43, 104, "R9");
    cyc(1, 45, 45, 0, 0, 0, 4, 0, 43, 104, "R9");
    cyc(0, 0, 45, 0, 0, 0, 4, 0, 43, 104, "R9");
    // R7: misc set ignored, int set applied
    cyc(0, 0, 70, 1, 70, 17, 2, 2, 1, 70, "R7");
    cyc(0, 0, 70, 1, 9, 50, 2, 2, 1, 70, "R7");
    cyc(0, 0, 9, 0, 0, 0, 2, 2, 1, 70, "R7");
    // R11: set and rename collide
    cyc(1, 12, 12, 1, 12, 33, 2, 2, 20, 70, "R10");
    cyc(0, 0, 12, 0, 0, 0, 2, 2, 20, 70, "R11");
    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int ra, la, sa, ic, fc;
      bit sv;
      ra = $urandom_range(NARCH - 1);
      la = ($urandom_range(3) == 0) ? ra : $urandom_range(NARCH - 1);
      sv = ($urandom_range(7) == 0);
      sa = ($urandom_range(1) == 0) ? ra : $urandom_range(NARCH - 1);
      ic = ($urandom_range(4) == 0) ? 0 : $urandom_range(20);
      fc = ($urandom_range(4) == 0) ? 0 : $urandom_range(20);
      cyc($urandom_range(3) != 0, ra, la, sv, sa, $urandom_range(NPHYS - 1), ic, fc,
          $urandom_range(NPI - 1), NPI + $urandom_range(NPF - 1), "R6");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule